// File: doc/BRIEF.md
# Burst Memory-Copy DMA Engine

This block is a single-channel copy engine. Software gives it a source base, a destination base and a count, then starts it by writing a request bit in the control word. The engine then moves the data over a simple request/ready memory port. It reads a unit from the source and then writes that unit to the destination. A unit is either a 16-byte burst of four 32-bit beats or, with bursts off, a single 32-bit word. The engine repeats this until the count is used up.

Each address moves on its own rule. It can step up or down by one word per beat, and the source can also be held fixed. Completion and failure are sticky flags in the control word. A failure is either a base address that is not aligned to the unit size or an error response from the bus. An optional interrupt follows those flags. Software clears stale flags, arms the engine, raises the request bit, and polls until one of the two flags appears.

Top module: `burst_copy_dma`

## Requirements
- R1: After reset every register reads zero, the bus request is low and the interrupt is low.
- R2: Control word (register index 0) holds enable at bit 0, a mode field at bits 3:2, destination decrement at bit 4, source decrement at bit 5, source hold at bit 7, interrupt enable at bit 8, burst enable at bit 9, a width field at bits 13:12 and a demand bit at bit 15. These read back as written. Every other bit except request (16), done (18) and error (20) reads zero. Register indices are 1 = source base, 2 = destination base and 3 = count.
- R3: Writing 1 to request (bit 16) starts a transfer only if enable was already stored as 1 and the engine is idle. Otherwise the write is ignored. Request reads 0 once the transfer has begun.
- R4: With burst enable set, each count unit reads four consecutive beats and then writes those four beats. Done (bit 18) sets after the last write. A count of zero sets done at once, with no bus access.
- R5: With burst enable clear, each count unit moves exactly one 32-bit word.
- R6: A beat address steps by +4 per beat, or by −4 when its decrement bit is 1. Source hold makes every read use the source base.
- R7: If a base is not 16-byte aligned in burst mode, or not 4-byte aligned in word mode, error (bit 20) sets and no bus access occurs.
- R8: An error response on any beat sets error, ends the transfer with no further request, and leaves done clear.
- R9: Done and error stay set until 1 is written to their own bit, or until enable is written from 0 to 1. Clearing enable alone keeps them.
- R10: The interrupt is high exactly while interrupt enable is set and done or error is set.
- R11: Once a bus request is raised, the request, direction, address and write data stay unchanged until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | ADDR_W | Byte address of the beat |
| bus_wdata | output | DATA_W | Write beat data |
| bus_rdata | input | DATA_W | Read beat data, valid with ready |
| bus_ready | input | 1 | Beat accepted |
| bus_err | input | 1 | Error response, valid with ready |
| irq | output | 1 | Stop interrupt |

## Verification
The bench targets the cases that are easy to get wrong.

- **Descending and held addresses.** A design that ignored a direction bit would scatter words above the destination window or read the wrong source words.
- **Misaligned bases in each mode.** A missing check would write partial bursts at the wrong place.
- **Zero count.** This must finish without touching the bus. A design that decremented first would wrap and copy a very long block.
- **Request written while disabled.** This must leave the engine silent.
- **Bus error mid-block.** Only the bursts before the error may land.
- **Flag lifetime.** Clearing enable must not drop done, while re-arming or writing the bit back must drop it. A design that mixed these up would lose completions or report stale ones.

// File: rtl/dma_copy_pkg.sv
// Package: shared bit positions, configuration type and sequencer states
// for the burst copy engine. Assumes a 32-bit register data path.
package dma_copy_pkg;
    localparam int CB_EN     = 0;
    localparam int CB_DDIR   = 4;
    localparam int CB_SDIR   = 5;
    localparam int CB_SFIX   = 7;
    localparam int CB_SIEN   = 8;
    localparam int CB_BURST  = 9;
    localparam int CB_SWREQ  = 16;
    localparam int CB_TC     = 18;
    localparam int CB_ERR    = 20;
    // Bits kept verbatim from a control write: enable, mode, directions,
    // hold, interrupt enable, burst, width field, demand.
    localparam logic [31:0] CFG_KEEP = 32'h0000_B3BD;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_SRC  = 2'd1;
    localparam logic [1:0] RA_DST  = 2'd2;
    localparam logic [1:0] RA_CNT  = 2'd3;

    typedef struct packed {
        logic burst;
        logic sfix;
        logic sdir;
        logic ddir;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma_copy_addr.sv
// Address generator: loads a base byte address, then steps it by STEP
// bytes up or down per accepted beat, or holds it when told to.
// Assumes load and step are never asserted in the same cycle.
module dma_copy_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          dec,
    input  logic          hold,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Pointer register: reset, load from base, or advance one beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step && !hold)
            addr <= dec ? (addr - STEP_V) : (addr + STEP_V);
    end
endmodule

// File: rtl/dma_copy_regs.sv
// Register file: control word with sticky done/error flags, request bit
// that self-clears on start, source/destination bases and count.
// Assumes reads are combinational and writes take effect on the edge.
module dma_copy_regs
    import dma_copy_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy,
    input  logic          seq_done,
    input  logic          seq_err,
    output logic          start,
    output xfer_cfg_t     cfg,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [CW-1:0] xfer_cnt,
    output logic          irq
);
    logic [31:0] cfg_q;
    logic        swreq_q, tc_q, err_q;
    logic        ctrl_wr, en_rise;

    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign en_rise = ctrl_wr && reg_wdata[CB_EN] && !cfg_q[CB_EN];
    assign start   = swreq_q && !busy;
    assign irq     = cfg_q[CB_SIEN] && (tc_q || err_q);
    assign cfg     = '{burst: cfg_q[CB_BURST], sfix: cfg_q[CB_SFIX],
                       sdir: cfg_q[CB_SDIR], ddir: cfg_q[CB_DDIR]};

    // Configuration bits: stored masked on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (ctrl_wr) cfg_q <= reg_wdata & CFG_KEEP;
    end

    // Request bit: set when armed and idle, cleared when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            swreq_q <= 1'b0;
        else if (start)
            swreq_q <= 1'b0;
        else if (ctrl_wr && reg_wdata[CB_SWREQ] && cfg_q[CB_EN] && !busy)
            swreq_q <= 1'b1;
    end

    // Sticky flags: set by the sequencer, cleared by write-one or re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (seq_done)
                tc_q <= 1'b1;
            else if (ctrl_wr && (reg_wdata[CB_TC] || en_rise))
                tc_q <= 1'b0;
            if (seq_err)
                err_q <= 1'b1;
            else if (ctrl_wr && (reg_wdata[CB_ERR] || en_rise))
                err_q <= 1'b0;
        end
    end

    // Base and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            xfer_cnt <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_SRC:  src_base <= reg_wdata[AW-1:0];
                RA_DST:  dst_base <= reg_wdata[AW-1:0];
                RA_CNT:  xfer_cnt <= reg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata            = cfg_q;
                reg_rdata[CB_SWREQ]  = swreq_q;
                reg_rdata[CB_TC]     = tc_q;
                reg_rdata[CB_ERR]    = err_q;
            end
            RA_SRC:  reg_rdata[AW-1:0] = src_base;
            RA_DST:  reg_rdata[AW-1:0] = dst_base;
            default: reg_rdata[CW-1:0] = xfer_cnt;
        endcase
    end

    assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q && !ctrl_wr |=> tc_q);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !ctrl_wr |=> err_q);
    assert_swreq_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !swreq_q);
endmodule

// File: rtl/dma_copy_seq.sv
// Transfer sequencer: checks alignment and count at start, then per unit
// reads BEATS beats (or one in word mode) into a local buffer and writes
// them back out. Ends on count exhaustion or on a bus error response.
// Assumes bus_rdata and bus_err are valid in the cycle bus_ready is high.
module dma_copy_seq
    import dma_copy_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  xfer_cfg_t     cfg,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] xfer_cnt,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output xfer_cfg_t     run_cfg,
    output logic          gen_load,
    output logic          src_step,
    output logic          dst_step,
    output logic          busy,
    output logic          done_p,
    output logic          err_p,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    input  logic          bus_err
);
    localparam int WORD_BYTES  = DW / 8;
    localparam int UNIT_BYTES  = BEATS * WORD_BYTES;
    localparam int WORD_LSB    = $clog2(WORD_BYTES);
    localparam int UNIT_LSB    = $clog2(UNIT_BYTES);
    localparam int BEAT_W      = $clog2(BEATS);

    seq_state_t        state_q;
    logic [CW-1:0]     left_q;
    logic [BEAT_W-1:0] beat_q, last_beat;
    logic [DW-1:0]     data_q [BEATS];
    logic              hs, misal, take, zero_cnt, last_unit;

    assign hs        = bus_req && bus_ready;
    assign take      = (state_q == SQ_IDLE) && start;
    assign zero_cnt  = (xfer_cnt == '0);
    assign misal     = cfg.burst ?
                       ((|src_base[UNIT_LSB-1:0]) || (|dst_base[UNIT_LSB-1:0])) :
                       ((|src_base[WORD_LSB-1:0]) || (|dst_base[WORD_LSB-1:0]));
    assign last_beat = run_cfg.burst ? BEAT_W'(BEATS - 1) : '0;
    assign last_unit = (left_q == CW'(1));

    assign busy      = (state_q != SQ_IDLE);
    assign bus_req   = busy;
    assign bus_we    = (state_q == SQ_WRITE);
    assign bus_addr  = bus_we ? dst_addr : src_addr;
    assign bus_wdata = data_q[beat_q];
    assign gen_load  = take && !zero_cnt && !misal;
    assign src_step  = (state_q == SQ_READ)  && hs && !bus_err;
    assign dst_step  = (state_q == SQ_WRITE) && hs && !bus_err;
    assign err_p     = (take && !zero_cnt && misal) || (hs && bus_err);
    assign done_p    = (take && zero_cnt) ||
                       (dst_step && (beat_q == last_beat) && last_unit);

    // Sequencer state, unit counter, beat index and captured config.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            left_q  <= '0;
            beat_q  <= '0;
            run_cfg <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (gen_load) begin
                    state_q <= SQ_READ;
                    left_q  <= xfer_cnt;
                    beat_q  <= '0;
                    run_cfg <= cfg;
                end
                SQ_READ: if (hs) begin
                    if (bus_err) begin
                        state_q <= SQ_IDLE;
                    end else if (beat_q == last_beat) begin
                        beat_q  <= '0;
                        state_q <= SQ_WRITE;
                    end else begin
                        beat_q  <= beat_q + 1'b1;
                    end
                end
                SQ_WRITE: if (hs) begin
                    if (bus_err) begin
                        state_q <= SQ_IDLE;
                    end else if (beat_q == last_beat) begin
                        beat_q  <= '0;
                        left_q  <= left_q - 1'b1;
                        state_q <= last_unit ? SQ_IDLE : SQ_READ;
                    end else begin
                        beat_q  <= beat_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Beat buffer: captures each accepted read beat at its index.
    generate
        for (genvar b = 0; b < BEATS; b++) begin : g_buf
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[b] <= '0;
                else if (src_step && (beat_q == BEAT_W'(b)))
                    data_q[b] <= bus_rdata;
            end
        end
    endgenerate

    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_we) &&
        $stable(bus_addr) && $stable(bus_wdata));
    assert_abort_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hs && bus_err |=> !bus_req);
    assert_misaligned_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && !zero_cnt && misal |=> !bus_req);
    assert_zero_count_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && zero_cnt |=> !bus_req);
endmodule

// File: rtl/burst_copy_dma.sv
// Top: single-channel burst copy DMA. Ties the register file, the
// sequencer and one address generator per direction together.
// Assumes one requester on the memory port and DATA_W a power of two.
module burst_copy_dma
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    output logic              irq
);
    localparam int NGEN = 2;
    localparam int STEP = DATA_W / 8;

    xfer_cfg_t         cfg, run_cfg;
    logic [ADDR_W-1:0] src_base, dst_base, src_addr, dst_addr;
    logic [CNT_W-1:0]  xfer_cnt;
    logic              start, busy, done_p, err_p, gen_load, src_step, dst_step;
    logic [ADDR_W-1:0] g_base [NGEN];
    logic [ADDR_W-1:0] g_addr [NGEN];
    logic              g_step [NGEN];
    logic              g_dec  [NGEN];
    logic              g_hold [NGEN];

    dma_copy_regs #(.AW(ADDR_W), .CW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .seq_done(done_p), .seq_err(err_p), .start(start), .cfg(cfg),
        .src_base(src_base), .dst_base(dst_base), .xfer_cnt(xfer_cnt),
        .irq(irq)
    );

    dma_copy_seq #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .BEATS(BURST_BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
        .src_base(src_base), .dst_base(dst_base), .xfer_cnt(xfer_cnt),
        .src_addr(src_addr), .dst_addr(dst_addr), .run_cfg(run_cfg),
        .gen_load(gen_load), .src_step(src_step), .dst_step(dst_step),
        .busy(busy), .done_p(done_p), .err_p(err_p),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err)
    );

    // Generator inputs: index 0 walks the source, index 1 the destination.
    assign g_base[0] = src_base;
    assign g_step[0] = src_step;
    assign g_dec[0]  = run_cfg.sdir;
    assign g_hold[0] = run_cfg.sfix;
    assign g_base[1] = dst_base;
    assign g_step[1] = dst_step;
    assign g_dec[1]  = run_cfg.ddir;
    assign g_hold[1] = 1'b0;
    assign src_addr  = g_addr[0];
    assign dst_addr  = g_addr[1];

    generate
        for (genvar g = 0; g < NGEN; g++) begin : g_agen
            dma_copy_addr #(.AW(ADDR_W), .STEP(STEP)) u_agen (
                .clk(clk), .rst_n(rst_n), .load(gen_load), .base(g_base[g]),
                .step(g_step[g]), .dec(g_dec[g]), .hold(g_hold[g]),
                .addr(g_addr[g])
            );
        end
    endgenerate

    assert_irq_follows_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_addr != RA_CTRL) || (reg_rdata[CB_TC] || reg_rdata[CB_ERR]));
endmodule

// File: tb/burst_copy_dma_bench.sv
module burst_copy_dma_bench;
    localparam int MEMW = 256;
    localparam logic [31:0] EN = 32'h1, DDIR = 32'h10, SDIR = 32'h20,
        SFIX = 32'h80, SIEN = 32'h100, BURST = 32'h200, SWREQ = 32'h1_0000,
        TC = 32'h4_0000, ERR = 32'h10_0000;
    // {src[11:0], dst[11:0], cnt[7:0], burst, sfix, sdir, ddir, expect_err}
    localparam logic [36:0] VECS [8] = '{
        {12'h000, 12'h200, 8'd2, 5'b10000},
        {12'h040, 12'h300, 8'd1, 5'b11000},
        {12'h0F0, 12'h2F0, 8'd2, 5'b10110},
        {12'h104, 12'h200, 8'd1, 5'b10001},
        {12'h000, 12'h208, 8'd1, 5'b10001},
        {12'h014, 12'h214, 8'd3, 5'b00000},
        {12'h000, 12'h200, 8'd0, 5'b10000},
        {12'h080, 12'h380, 8'd1, 5'b10010}
    };

    logic clk = 0, rst_n = 0, reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic bus_req, bus_we, bus_ready, bus_err, irq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [31:0] mem [MEMW];
    logic [31:0] expm [MEMW];
    logic rdy = 0, init_go = 0, err_en = 0;
    logic [31:0] err_addr = 0;
    int tests = 0, fails = 0, req_cnt = 0, cycles = 0;

    always #10 clk = ~clk;

    burst_copy_dma u_burst_copy_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .irq(irq)
    );

    assign bus_ready = rdy;
    assign bus_err   = rdy && err_en && (bus_addr == err_addr);
    assign bus_rdata = mem[bus_addr[9:2]];

    // Memory model: one wait cycle per beat, writes land on acceptance.
    always @(posedge clk) begin
        rdy <= bus_req && !rdy;
        if (bus_req) req_cnt <= req_cnt + 1;
        if (init_go)
            for (int i = 0; i < MEMW; i++) mem[i] <= 32'hC0DE_0000 + i;
        else if (bus_req && rdy && bus_we && !bus_err)
            mem[bus_addr[9:2]] <= bus_wdata;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic mem_init();
        @(negedge clk); init_go = 1;
        @(negedge clk); init_go = 0;
        for (int i = 0; i < MEMW; i++) expm[i] = 32'hC0DE_0000 + i;
    endtask

    task automatic wait_flags(output logic [31:0] c);
        c = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(2'd0, c);
            if ((c & (TC | ERR)) != 0) break;
        end
    endtask

    task automatic mem_check(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < MEMW; i++)
            if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad == 0, req, mem[first], expm[first]);
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] n, input logic [31:0] c,
                       output logic [31:0] ctl);
        wr(2'd0, 0);
        wr(2'd1, s); wr(2'd2, d); wr(2'd3, n);
        wr(2'd0, c | EN);
        wr(2'd0, c | EN | SWREQ);
        wait_flags(ctl);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        rd(2'd0, v); check(v == 0, "R1 ctrl", v, 0);
        rd(2'd1, v); check(v == 0, "R1 src", v, 0);
        rd(2'd3, v); check(v == 0, "R1 cnt", v, 0);
        check(!irq && !bus_req, "R1 outputs", {irq, bus_req}, 0);

        // R2: readback mask
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check(v == 32'h0000_B3BD, "R2 readback", v, 32'h0000_B3BD);
        wr(2'd0, 0);

        // R3: request ignored when enable not stored
        mem_init();
        wr(2'd1, 0); wr(2'd2, 32'h200); wr(2'd3, 1);
        wr(2'd0, BURST | SWREQ);
        wr(2'd0, BURST | EN | SWREQ);
        repeat (10) @(negedge clk);
        check(req_cnt == 0, "R3 no access when disabled", req_cnt, 0);
        rd(2'd0, v); check(v == (BURST | EN), "R3 request dropped", v, BURST | EN);
        // R3: request self-clears once started
        wr(2'd0, BURST | EN | SWREQ);
        @(negedge clk);
        rd(2'd0, v); check(v[16] == 0 && bus_req, "R3 request cleared", v, BURST | EN);
        wait_flags(v);
        check(v == (BURST | EN | TC), "R3 done", v, BURST | EN | TC);

        // R10 / R9: interrupt and flag lifetime
        wr(2'd0, BURST | EN | SIEN);
        @(negedge clk); check(irq, "R10 irq with done", irq, 1);
        wr(2'd0, BURST | EN);
        rd(2'd0, v); check(!irq && v[18], "R10 irq masked, R9 done kept", {irq, v[18]}, 1);
        wr(2'd0, BURST);
        rd(2'd0, v); check(v[18], "R9 done kept after disable", v, BURST | TC);
        wr(2'd0, BURST | EN);
        rd(2'd0, v); check(!v[18], "R9 re-arm clears done", v, BURST | EN);
        wr(2'd3, 0);
        wr(2'd0, BURST | EN | SWREQ);
        wait_flags(v);
        wr(2'd0, BURST | EN | TC);
        rd(2'd0, v); check(v == (BURST | EN), "R9 write-one clears done", v, BURST | EN);

        // Vector table: R4 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            logic [36:0] e;
            logic [31:0] s, d, n, c, ctl, sa, da;
            int beats;
            e = VECS[k];
            s = {20'd0, e[36:25]}; d = {20'd0, e[24:13]}; n = {24'd0, e[12:5]};
            c = (e[4] ? BURST : 0) | (e[3] ? SFIX : 0) | (e[2] ? SDIR : 0) |
                (e[1] ? DDIR : 0);
            mem_init();
            beats = e[4] ? 4 : 1;
            if (!e[0])
                for (int b = 0; b < n * beats; b++) begin
                    sa = e[3] ? s : (e[2] ? s - 4 * b : s + 4 * b);
                    da = e[1] ? d - 4 * b : d + 4 * b;
                    expm[da[9:2]] = 32'hC0DE_0000 + sa[9:2];
                end
            run(s, d, n, c, ctl);
            if (e[0])
                check(ctl[20] && !ctl[18], "R7 misaligned flags", ctl, c | EN | ERR);
            else
                check(ctl[18] && !ctl[20], "R4 R5 R6 done flags", ctl, c | EN | TC);
            mem_check(e[0] ? "R7 no writes" : "R4 R5 R6 copy contents");
        end

        // R8: error response on second burst read
        mem_init();
        for (int b = 0; b < 4; b++) expm[(32'h200 >> 2) + b] = 32'hC0DE_0000 + b;
        err_addr = 32'h10; err_en = 1;
        run(0, 32'h200, 3, BURST, v);
        check(v == (BURST | EN | ERR), "R8 error flags", v, BURST | EN | ERR);
        check(!bus_req, "R8 no further request", bus_req, 0);
        mem_check("R8 partial copy");
        err_en = 0;

        summary();
    end
endmodule